// File: doc/BRIEF.md
# Sequential fetch mask generator

This block sits after the instruction cache read and the branch predictor lookup in a wide fetch stage. Each cycle the cache returns two adjacent lines, 32 instruction slots in all, and a predecode type for every slot. The block starts at the slot that the fetch address names inside the first line. It walks forward and keeps instructions until one rule closes the group. It returns a contiguous valid mask over the 32 slots, the number of kept instructions, the address of the next fetch and a code that says why the group ended.

The predictor side provides one direction bit for each control transfer the group may hold, in group order. It also provides one target buffer result (hit, target, and a flag that says whether the predicted target leaves the sequential path) and the return stack top. Targets of PC-relative jumps, calls and conditional branches are computed inside the block from the slot address and the slot's word displacement. An indirect jump whose buffered target stays on the sequential path does not end the group.

A request is accepted on a clock edge with `req_valid` high. A two-state controller (IDLE, EMIT) then presents the result for one cycle. IDLE goes to EMIT on a request. EMIT stays in EMIT when a new request arrives and falls back to IDLE when none does. The result registers hold their values between requests.

Top module: `fetch_mask_gen`

## Requirements
- R1: The group starts at slot `fetch_pc[5:2]` of the first line and may run on into the second line (slots 16 to 31). The mask is one contiguous run from the start slot, `grp_count` equals its population count, and the slot that ends the group is inside the mask.
- R2: When the 16th instruction is kept and no other rule applies, the group ends with stop code 0. The next address is the address of the slot after the last kept one.
- R3: When the third control transfer is kept and it does not itself redirect fetch, the group ends with stop code 1 and a sequential next address. Kinds 1 to 5 are control transfers.
- R4: A conditional branch (kind 1) reads `pred_taken[k]`, where k is the number of control transfers before it in the group. If that bit is set, the group ends with stop code 2 and the next address is slot address + 4 × signed 12-bit displacement.
- R5: A direct jump (kind 2) and a direct call (kind 3) always end the group with code 2 at the PC-relative target. A return (kind 4) ends it with code 2 at `ras_top`.
- R6: The first indirect jump (kind 5) of a group behaves as follows. On a buffer hit with the leave-sequence flag clear, it is kept and fetch continues. On a hit with the flag set, the group ends with code 3 at `btb_target`. On a buffer miss, or at a second indirect jump in the same group, the group ends with code 5 and a sequential next address.
- R7: A system call (kind 6) ends the group with code 4 and a sequential next address.
- R8: When the slot that ends the group is also the 16th instruction or the third transfer, its own redirect code (2, 3, 4, 5) wins. If the third transfer is also the 16th instruction, the code is 1.
- R9: After reset, all outputs are zero. `grp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the outputs show that request's result.
- R10: Slot kinds are 3-bit fields at `slot_kind[3i+2:3i]`: 0 plain, 1 conditional, 2 jump, 3 call, 4 return, 5 indirect, 6 system call, 7 treated as plain. Displacements are 12-bit fields at `slot_disp[12i+11:12i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Evaluate a fetch group this cycle |
| fetch_pc | input | 30 | Word address of the first instruction (byte address bits 31:2) |
| slot_kind | input | 96 | Predecoded kind for each of the 32 slots |
| slot_disp | input | 384 | Signed word displacement for each slot |
| pred_taken | input | 3 | Direction bits, one per control transfer in group order |
| btb_hit | input | 1 | Target buffer hit for the group's indirect jump |
| btb_break | input | 1 | Buffered target leaves the sequential path |
| btb_target | input | 32 | Buffered indirect target |
| ras_top | input | 32 | Top of the return address stack |
| grp_valid | output | 1 | Result valid |
| grp_mask | output | 32 | Valid instruction mask over both lines |
| grp_count | output | 5 | Number of instructions kept |
| grp_next_pc | output | 32 | Next fetch byte address |
| grp_stop | output | 3 | Stop code 0 to 5 |

## Verification
Three rules can close a group on the same slot: the 16-instruction limit, the three-transfer limit, and the slot's own redirect (taken branch, indirect break, miss, system call). The bench moves a single transfer of each flavour across every start offset and every window position. This puts the redirect exactly on the 16th slot and on line crossings. Directed groups also place a not-taken third branch, and a taken branch, at the 16th position. Every result is compared in full against an arithmetic model of the rule order, so a wrong priority shows up as a wrong stop code and a wrong next address.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_COND  = 3'd1,
        K_JUMP  = 3'd2,
        K_CALL  = 3'd3,
        K_RET   = 3'd4,
        K_IND   = 3'd5,
        K_SYS   = 3'd6,
        K_RSVD  = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        STOP_LIMIT = 3'd0,
        STOP_BRCNT = 3'd1,
        STOP_TAKEN = 3'd2,
        STOP_IBRK  = 3'd3,
        STOP_SYS   = 3'd4,
        STOP_MISS  = 3'd5
    } stop_e;

    typedef enum logic [1:0] {
        TGT_SEQ = 2'd0,
        TGT_REL = 2'd1,
        TGT_RAS = 2'd2,
        TGT_BTB = 2'd3
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fsm_e;

endpackage

// File: rtl/fmg_slot_decode.sv
// Per-slot predecode cleanup: kind normalisation and displacement scaling.
module fmg_slot_decode
    import fmg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 12
) (
    input  logic [2:0]        raw_kind,
    input  logic [DISP_W-1:0] raw_disp,
    output kind_e             kind,
    output logic [ADDR_W-1:0] byte_disp
);
    localparam int EXT_W = ADDR_W - DISP_W - 2;

    always_comb begin
        kind = (raw_kind == 3'd7) ? K_PLAIN : kind_e'(raw_kind);
        byte_disp = {{EXT_W{raw_disp[DISP_W-1]}}, raw_disp, 2'b00};
    end
endmodule

// File: rtl/fmg_scan.sv
// Walks the slot window from the start offset and applies the stop rules.
module fmg_scan
    import fmg_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int OFS_W     = 4,
    parameter int SLOT_W    = 5,
    parameter int CNT_W     = 5,
    parameter int BR_W      = 2,
    parameter int MAX_INSNS = 16,
    parameter int MAX_BR    = 3
) (
    input  logic [OFS_W-1:0]  start,
    input  kind_e             kind_v [SLOTS],
    input  logic [MAX_BR-1:0] pred_taken,
    input  logic              btb_hit,
    input  logic              btb_break,
    output logic [SLOTS-1:0]  mask,
    output logic [CNT_W-1:0]  count,
    output stop_e             stop,
    output tgt_e              sel,
    output logic [SLOT_W-1:0] stop_slot
);
    logic [BR_W-1:0] brs;
    logic            done;
    logic            ind_used;
    logic            fired;

    always_comb begin
        mask      = '0;
        count     = '0;
        brs       = '0;
        stop      = STOP_LIMIT;
        sel       = TGT_SEQ;
        stop_slot = '0;
        done      = 1'b0;
        ind_used  = 1'b0;
        fired     = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!done && (i >= int'(start))) begin
                mask[i] = 1'b1;
                count   = count + 1'b1;
                fired   = 1'b0;
                case (kind_v[i])
                    K_COND: begin
                        if (pred_taken[brs]) begin
                            fired = 1'b1;
                            stop  = STOP_TAKEN;
                            sel   = TGT_REL;
                        end
                        brs = brs + 1'b1;
                    end
                    K_JUMP, K_CALL: begin
                        brs   = brs + 1'b1;
                        fired = 1'b1;
                        stop  = STOP_TAKEN;
                        sel   = TGT_REL;
                    end
                    K_RET: begin
                        brs   = brs + 1'b1;
                        fired = 1'b1;
                        stop  = STOP_TAKEN;
                        sel   = TGT_RAS;
                    end
                    K_IND: begin
                        brs = brs + 1'b1;
                        if (ind_used || !btb_hit) begin
                            fired = 1'b1;
                            stop  = STOP_MISS;
                            sel   = TGT_SEQ;
                        end else if (btb_break) begin
                            fired = 1'b1;
                            stop  = STOP_IBRK;
                            sel   = TGT_BTB;
                        end else begin
                            ind_used = 1'b1;
                        end
                    end
                    K_SYS: begin
                        fired = 1'b1;
                        stop  = STOP_SYS;
                        sel   = TGT_SEQ;
                    end
                    default: ;
                endcase
                // Redirect codes outrank the two counting limits (R8).
                if (!fired) begin
                    if (brs == BR_W'(MAX_BR)) begin
                        fired = 1'b1;
                        stop  = STOP_BRCNT;
                        sel   = TGT_SEQ;
                    end else if (count == CNT_W'(MAX_INSNS)) begin
                        fired = 1'b1;
                        stop  = STOP_LIMIT;
                        sel   = TGT_SEQ;
                    end
                end
                if (fired) begin
                    done      = 1'b1;
                    stop_slot = SLOT_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/fmg_target.sv
// Forms the next fetch address from the slot that closed the group.
module fmg_target
    import fmg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 32,
    parameter int SLOT_W = 5
) (
    input  logic [ADDR_W-1:0] line_base,
    input  logic [SLOT_W-1:0] stop_slot,
    input  tgt_e              sel,
    input  logic [ADDR_W-1:0] byte_disp [SLOTS],
    input  logic [ADDR_W-1:0] btb_target,
    input  logic [ADDR_W-1:0] ras_top,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] slot_pc;

    always_comb begin
        slot_pc = line_base + ADDR_W'({stop_slot, 2'b00});
        unique case (sel)
            TGT_SEQ: next_pc = slot_pc + ADDR_W'(4);
            TGT_REL: next_pc = slot_pc + byte_disp[stop_slot];
            TGT_RAS: next_pc = ras_top;
            TGT_BTB: next_pc = btb_target;
            default: next_pc = slot_pc + ADDR_W'(4);
        endcase
    end
endmodule

// File: rtl/fetch_mask_gen.sv
module fetch_mask_gen
    import fmg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE      = 16,
    parameter int DISP_W    = 12,
    parameter int MAX_INSNS = 16,
    parameter int MAX_BR    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:2]              fetch_pc,
    input  logic [2*LINE*3-1:0]            slot_kind,
    input  logic [2*LINE*DISP_W-1:0]       slot_disp,
    input  logic [MAX_BR-1:0]              pred_taken,
    input  logic                           btb_hit,
    input  logic                           btb_break,
    input  logic [ADDR_W-1:0]              btb_target,
    input  logic [ADDR_W-1:0]              ras_top,
    output logic                           grp_valid,
    output logic [2*LINE-1:0]              grp_mask,
    output logic [$clog2(MAX_INSNS+1)-1:0] grp_count,
    output logic [ADDR_W-1:0]              grp_next_pc,
    output logic [2:0]                     grp_stop
);
    // MAX_INSNS must not exceed LINE+1 so the window never runs dry.
    localparam int SLOTS  = 2 * LINE;
    localparam int OFS_W  = $clog2(LINE);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LB     = OFS_W + 2;
    localparam int CNT_W  = $clog2(MAX_INSNS + 1);
    localparam int BR_W   = $clog2(MAX_BR + 1);

    kind_e             kind_v    [SLOTS];
    logic [ADDR_W-1:0] byte_disp [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            fmg_slot_decode #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dec (
                .raw_kind  (slot_kind[g*3 +: 3]),
                .raw_disp  (slot_disp[g*DISP_W +: DISP_W]),
                .kind      (kind_v[g]),
                .byte_disp (byte_disp[g])
            );
        end
    endgenerate

    logic [OFS_W-1:0]  start;
    logic [ADDR_W-1:0] line_base;
    logic [SLOTS-1:0]  scan_mask;
    logic [CNT_W-1:0]  scan_count;
    stop_e             scan_stop;
    tgt_e              scan_sel;
    logic [SLOT_W-1:0] scan_slot;
    logic [ADDR_W-1:0] scan_next;

    assign start     = fetch_pc[LB-1:2];
    assign line_base = {fetch_pc[ADDR_W-1:LB], {LB{1'b0}}};

    fmg_scan #(
        .SLOTS(SLOTS), .OFS_W(OFS_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
        .BR_W(BR_W), .MAX_INSNS(MAX_INSNS), .MAX_BR(MAX_BR)
    ) u_scan (
        .start      (start),
        .kind_v     (kind_v),
        .pred_taken (pred_taken),
        .btb_hit    (btb_hit),
        .btb_break  (btb_break),
        .mask       (scan_mask),
        .count      (scan_count),
        .stop       (scan_stop),
        .sel        (scan_sel),
        .stop_slot  (scan_slot)
    );

    fmg_target #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_tgt (
        .line_base  (line_base),
        .stop_slot  (scan_slot),
        .sel        (scan_sel),
        .byte_disp  (byte_disp),
        .btb_target (btb_target),
        .ras_top    (ras_top),
        .next_pc    (scan_next)
    );

    // Result controller
    fsm_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = req_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_mask    <= '0;
            grp_count   <= '0;
            grp_next_pc <= '0;
            grp_stop    <= '0;
        end else if (req_valid) begin
            grp_mask    <= scan_mask;
            grp_count   <= scan_count;
            grp_next_pc <= scan_next;
            grp_stop    <= scan_stop;
        end
    end

    assign grp_valid = (state == ST_EMIT);

    a_r1_count_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (int'(grp_count) == $countones(grp_mask)));

    a_r1_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (((grp_mask + (grp_mask & (~grp_mask + 1'b1))) & grp_mask) == '0));

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_count != '0 && int'(grp_count) <= MAX_INSNS));

    a_r2_limit_full: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_stop == STOP_LIMIT) |-> (int'(grp_count) == MAX_INSNS));

    a_r9_emit_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> grp_valid);

    a_r9_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grp_valid);

    a_r10_stop_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_stop <= 3'd5));
endmodule

// File: tb/fetch_mask_gen_test.sv
module fetch_mask_gen_test;
    localparam int SLOTS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       pc_b = '0;
    logic [SLOTS*3-1:0]  kinds = '0;
    logic [SLOTS*12-1:0] disps = '0;
    logic [2:0]        pred = '0;
    logic              bhit = 1'b0;
    logic              bbrk = 1'b0;
    logic [31:0]       btgt = '0;
    logic [31:0]       ras = '0;

    logic              grp_valid;
    logic [SLOTS-1:0]  grp_mask;
    logic [4:0]        grp_count;
    logic [31:0]       grp_next_pc;
    logic [2:0]        grp_stop;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fetch_mask_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .fetch_pc(pc_b[31:2]), .slot_kind(kinds), .slot_disp(disps),
        .pred_taken(pred), .btb_hit(bhit), .btb_break(bbrk),
        .btb_target(btgt), .ras_top(ras),
        .grp_valid(grp_valid), .grp_mask(grp_mask), .grp_count(grp_count),
        .grp_next_pc(grp_next_pc), .grp_stop(grp_stop)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Arithmetic model of the rules as stated in the requirements.
    task automatic model(output logic [SLOTS-1:0] m, output int c,
                         output logic [31:0] np, output int sc);
        int brs = 0;
        bit ind_used = 0;
        bit done = 0;
        int s = int'(pc_b[5:2]);
        logic [31:0] base = {pc_b[31:6], 6'b0};
        m = '0; c = 0; np = '0; sc = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!done && i >= s) begin
                logic [31:0] pci = base + 32'(i * 4);
                logic signed [11:0] d = disps[i*12 +: 12];
                logic [31:0] rel = pci + 32'(int'(d) * 4);
                int k = int'(kinds[i*3 +: 3]);
                bit f = 0;
                m[i] = 1'b1;
                c++;
                case (k)
                    1: begin
                        if (pred[brs]) begin f = 1; sc = 2; np = rel; end
                        brs++;
                    end
                    2, 3: begin brs++; f = 1; sc = 2; np = rel; end
                    4: begin brs++; f = 1; sc = 2; np = ras; end
                    5: begin
                        brs++;
                        if (ind_used || !bhit) begin f = 1; sc = 5; np = pci + 4; end
                        else if (bbrk) begin f = 1; sc = 3; np = btgt; end
                        else ind_used = 1;
                    end
                    6: begin f = 1; sc = 4; np = pci + 4; end
                    default: ;
                endcase
                if (!f) begin
                    if (brs == 3) begin f = 1; sc = 1; np = pci + 4; end
                    else if (c == 16) begin f = 1; sc = 0; np = pci + 4; end
                end
                if (f) done = 1;
            end
        end
    endtask

    function automatic string stop_tag(input int sc);
        case (sc)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic run_case(input string extra);
        logic [SLOTS-1:0] m;
        int c;
        int sc;
        logic [31:0] np;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        model(m, c, np, sc);
        check(grp_valid == 1'b1, "R9", "valid", 64'(grp_valid), 64'd1);
        check(grp_mask == m, "R1", "mask", 64'(grp_mask), 64'(m));
        check(int'(grp_count) == c, "R1", "count", 64'(grp_count), 64'(c));
        check(int'(grp_stop) == sc, {stop_tag(sc), extra}, "stop", 64'(grp_stop), 64'(sc));
        check(grp_next_pc == np, {stop_tag(sc), extra}, "next_pc", 64'(grp_next_pc), 64'(np));
    endtask

    task automatic set_kind(input int slot, input int k);
        kinds[slot*3 +: 3] = 3'(k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(grp_valid == 1'b0, "R9", "reset valid", 64'(grp_valid), 64'd0);
        check(grp_mask == '0 && grp_count == '0 && grp_stop == '0 && grp_next_pc == '0,
              "R9", "reset outputs", 64'(grp_count), 64'd0);
        rst_n = 1'b1;

        // R2: straight-line code from every start offset
        for (int s = 0; s < 16; s++) begin
            pc_b = 32'h0000_4000 + 32'(s * 4);
            kinds = '0;
            run_case(" limit sweep");
        end

        // R4 R5 R6 R7 R8: one transfer of each flavour at every window position
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 18; p++) begin
                for (int v = 0; v < 9; v++) begin
                    pc_b = 32'h0012_3400 + 32'(s * 4);
                    kinds = '0;
                    disps = '0;
                    disps[(s+p)*12 +: 12] = 12'(v * 37 - 150);
                    bhit = 1'b0; bbrk = 1'b0; pred = 3'b000;
                    btgt = 32'h00AB_CD10; ras = 32'h0077_0040;
                    case (v)
                        0: begin set_kind(s+p, 1); pred = 3'b001; end
                        1: set_kind(s+p, 1);
                        2: set_kind(s+p, 2);
                        3: set_kind(s+p, 3);
                        4: set_kind(s+p, 4);
                        5: set_kind(s+p, 5);
                        6: begin set_kind(s+p, 5); bhit = 1'b1; bbrk = 1'b1; end
                        7: begin set_kind(s+p, 5); bhit = 1'b1; end
                        default: set_kind(s+p, 6);
                    endcase
                    run_case(" position sweep R8");
                end
            end
        end

        // R3 R8: three not-taken branches, third on the 16th slot
        pc_b = 32'h0000_8008; kinds = '0; pred = 3'b000;
        set_kind(3, 1); set_kind(9, 1); set_kind(17, 1);
        run_case(" R8 third transfer at limit");
        check(grp_stop == 3'd1, "R8", "brcount at 16th", 64'(grp_stop), 64'd1);

        // R8: taken branch on the 16th slot keeps code 2
        kinds = '0; pred = 3'b100; disps = '0; disps[17*12 +: 12] = 12'hFF0;
        set_kind(3, 1); set_kind(9, 1); set_kind(17, 1);
        run_case(" R8 taken at limit");
        check(grp_stop == 3'd2, "R8", "taken wins", 64'(grp_stop), 64'd2);

        // R6: second indirect in a group ends as a miss
        pc_b = 32'h0000_9000; kinds = '0; bhit = 1'b1; bbrk = 1'b0;
        set_kind(2, 5); set_kind(6, 5);
        run_case(" second indirect");
        check(grp_stop == 3'd5 && grp_count == 5'd7, "R6", "second indirect",
              64'(grp_count), 64'd7);

        // R10: reserved kind 7 behaves as plain; R9 quiet after request
        kinds = '0; set_kind(0, 7); set_kind(5, 7);
        run_case(" R10 reserved kind");
        check(grp_stop == 3'd0 && grp_count == 5'd16, "R10", "kind 7 plain",
              64'(grp_count), 64'd16);
        @(negedge clk);
        check(grp_valid == 1'b0, "R9", "idle after result", 64'(grp_valid), 64'd0);

        // Mixed patterns over all rules
        void'($urandom(7));
        for (int n = 0; n < 3000; n++) begin
            pc_b = {$urandom(), 2'b00};
            for (int i = 0; i < SLOTS; i++)
                kinds[i*3 +: 3] = ($urandom % 16 < 10) ? 3'd0 : 3'($urandom % 8);
            for (int i = 0; i < SLOTS; i++) disps[i*12 +: 12] = 12'($urandom);
            pred = 3'($urandom); bhit = 1'($urandom); bbrk = 1'($urandom);
            btgt = $urandom; ras = $urandom;
            run_case(" mixed");
            if (n % 50 == 0) begin
                @(negedge clk);
                check(grp_valid == 1'b0, "R9", "gap cycle", 64'(grp_valid), 64'd0);
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule